// File: doc/BRIEF.md
# Registered bidirectional bus transceiver

This block moves data, without inversion, between an A port and a B port. The port word is split into independent halves (two halves of eight bits by default), and each half has its own control set. Each half keeps two storage registers. The A register samples the A port when its A-to-B capture strobe rises. The B register samples the B port when its B-to-A capture strobe rises. Capture takes place whatever the selects and enables are set to.

For each direction, a select chooses between the live data on the opposite port and the stored register value. Two enables decide which port, if either, the block drives: the A-to-B enable is active high, and the B-to-A enable is active low. Together these controls give isolation, storage, live transfer, stored transfer and a bus-hold loop. Each three-state pad is brought out as a separate input vector, output vector and per-half output enable, and the pad is resolved outside the block.

Every output is registered on the system clock, so the block contains no combinational path from an input port to an output port. The result of the controls and data sampled at clock edge k appears at the outputs after edge k. A capture strobe is a level signal, sampled on the system clock, whose 0-to-1 change marks a capture. When a stored output captures on a given edge, it shows the value captured on that same edge.

Top module: `bidir_reg_xcvr`

## Requirements
- R1: A synchronous active-high reset clears both storage registers in every half. In the first cycle after reset, every output data bit is 0 and both enables of every half are low.
- R2: When the A-to-B capture strobe of a half changes from 0 to 1 between two clock samples, the A register of that half loads that half's A-port input. This happens for any setting of the selects and enables.
- R3: When the B-to-A capture strobe of a half changes from 0 to 1 between two clock samples, the B register of that half loads that half's B-port input. This happens for any setting of the selects and enables.
- R4: In a cycle with no capture edge, a storage register keeps its value. A stored output therefore does not change when the port it was captured from changes.
- R5: The B-port enable of a half equals that half's A-to-B enable (1 = drive). The A-port enable equals the inverse of the B-to-A enable (0 = drive). Both take effect one clock after they are sampled.
- R6: Isolation: when the A-to-B enable is 0 and the B-to-A enable is 1, neither port of that half is driven. Captures still work in this mode.
- R7: When a select is 0, its output carries, one clock later and without inversion, the live input of the opposite port. B output follows A input, and A output follows B input.
- R8: When a select is 1, its output carries the stored register: the A register drives the B output, and the B register drives the A output. If a capture happens on the same edge, the output shows the newly captured value. Both directions can run stored transfer at the same time.
- R9: While the A port is driven from live B data, a capture into the A register stores the B value. A simultaneous B capture then leaves the same value in both registers.
- R10: When both enables of a half are active and both selects are 0, the port values loop back on each other. After the outside driver releases, both ports keep their last value.
- R11: Half h occupies bits [8h+7:8h] of each data vector and bit h of each control and enable vector. The controls of one half never affect the other half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cap_ab | input | NUM_HALVES | A-register capture strobe per half, a 0-to-1 change captures |
| cap_ba | input | NUM_HALVES | B-register capture strobe per half, a 0-to-1 change captures |
| sel_ab | input | NUM_HALVES | B-output source per half: 0 live A, 1 stored A register |
| sel_ba | input | NUM_HALVES | A-output source per half: 0 live B, 1 stored B register |
| en_ab | input | NUM_HALVES | B-port drive enable per half, active high |
| en_ba_n | input | NUM_HALVES | A-port drive enable per half, active low |
| a_in | input | NUM_HALVES*HALF_W | Resolved A-port pad value |
| a_out | output | NUM_HALVES*HALF_W | Data the block drives onto the A port |
| a_oe | output | NUM_HALVES | A-port output enable per half |
| b_in | input | NUM_HALVES*HALF_W | Resolved B-port pad value |
| b_out | output | NUM_HALVES*HALF_W | Data the block drives onto the B port |
| b_oe | output | NUM_HALVES | B-port output enable per half |

## Verification
The assertions check, on every cycle and for each half, the following properties:
- Outputs are cleared after reset.
- Each enable has the correct polarity, and isolation leaves both ports undriven.
- The live path copies the opposite port.
- A capture edge with the stored select shows the captured value.
- With no capture edge, a stored output stays stable.

Some properties depend on how the pads resolve outside the block, so only the bench scenarios can show them:
- Storing the same value into both registers, which needs the A pad to carry live B data.
- The bus-hold loop after the external driver releases.
- Correct recovery of the stored values after a reset in the middle of a run.

The same holds for the independence of the two halves under mixed control settings.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    localparam int HALF_W_DEFAULT     = 8;
    localparam int NUM_HALVES_DEFAULT = 2;

    // Per-half control set, gathered from the flat port vectors.
    typedef struct packed {
        logic cap_ab;
        logic cap_ba;
        logic sel_ab;
        logic sel_ba;
        logic en_ab;
        logic en_ba_n;
    } half_ctrl_t;

    // Direction of a transfer slice; picks the enable polarity.
    typedef enum logic {
        DIR_A_TO_B = 1'b0,
        DIR_B_TO_A = 1'b1
    } xfer_dir_t;

    // Drive level of a pad enable given the raw control and the slice direction.
    function automatic logic drive_level(input logic en_raw, input xfer_dir_t dir);
        return (dir == DIR_B_TO_A) ? ~en_raw : en_raw;
    endfunction

    // True when a sampled strobe moved from 0 to 1.
    function automatic logic strobe_rose(input logic now_v, input logic prev_v);
        return now_v & ~prev_v;
    endfunction

endpackage

// File: rtl/xcvr_rise_det.sv
module xcvr_rise_det
    import xcvr_pkg::*;
(
    input  logic clk,
    input  logic strobe,
    output logic rose
);

    logic strobe_q;

    // Plain history flop: tracks the strobe through reset as well.
    always_ff @(posedge clk) begin
        strobe_q <= strobe;
    end

    always_comb begin
        rose = strobe_rose(strobe, strobe_q);
    end

endmodule

// File: rtl/xcvr_path.sv
module xcvr_path
    import xcvr_pkg::*;
#(
    parameter int        WIDTH = HALF_W_DEFAULT,
    parameter xfer_dir_t DIR   = DIR_A_TO_B
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cap_rise,
    input  logic             sel_stored,
    input  logic             en_raw,
    input  logic [WIDTH-1:0] src_port,
    output logic [WIDTH-1:0] dst_data,
    output logic             dst_oe
);

    logic [WIDTH-1:0] store_q;
    logic [WIDTH-1:0] store_nxt;
    logic [WIDTH-1:0] route_nxt;

    always_comb begin
        store_nxt = cap_rise ? src_port : store_q;
        route_nxt = sel_stored ? store_nxt : src_port;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            store_q  <= '0;
            dst_data <= '0;
            dst_oe   <= 1'b0;
        end else begin
            store_q  <= store_nxt;
            dst_data <= route_nxt;
            dst_oe   <= drive_level(en_raw, DIR);
        end
    end

endmodule

// File: rtl/xcvr_half.sv
module xcvr_half
    import xcvr_pkg::*;
#(
    parameter int WIDTH = HALF_W_DEFAULT
) (
    input  logic             clk,
    input  logic             rst,
    input  half_ctrl_t       ctrl,
    input  logic [WIDTH-1:0] a_pad,
    input  logic [WIDTH-1:0] b_pad,
    output logic [WIDTH-1:0] a_drv,
    output logic             a_drv_oe,
    output logic [WIDTH-1:0] b_drv,
    output logic             b_drv_oe
);

    logic rise_ab;
    logic rise_ba;

    xcvr_rise_det u_rise_ab (
        .clk    (clk),
        .strobe (ctrl.cap_ab),
        .rose   (rise_ab)
    );

    xcvr_rise_det u_rise_ba (
        .clk    (clk),
        .strobe (ctrl.cap_ba),
        .rose   (rise_ba)
    );

    // A register feeds the B port.
    xcvr_path #(.WIDTH(WIDTH), .DIR(DIR_A_TO_B)) u_path_ab (
        .clk        (clk),
        .rst        (rst),
        .cap_rise   (rise_ab),
        .sel_stored (ctrl.sel_ab),
        .en_raw     (ctrl.en_ab),
        .src_port   (a_pad),
        .dst_data   (b_drv),
        .dst_oe     (b_drv_oe)
    );

    // B register feeds the A port.
    xcvr_path #(.WIDTH(WIDTH), .DIR(DIR_B_TO_A)) u_path_ba (
        .clk        (clk),
        .rst        (rst),
        .cap_rise   (rise_ba),
        .sel_stored (ctrl.sel_ba),
        .en_raw     (ctrl.en_ba_n),
        .src_port   (b_pad),
        .dst_data   (a_drv),
        .dst_oe     (a_drv_oe)
    );

endmodule

// File: rtl/bidir_reg_xcvr.sv
module bidir_reg_xcvr
    import xcvr_pkg::*;
#(
    parameter int HALF_W     = HALF_W_DEFAULT,
    parameter int NUM_HALVES = NUM_HALVES_DEFAULT
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NUM_HALVES-1:0]        cap_ab,
    input  logic [NUM_HALVES-1:0]        cap_ba,
    input  logic [NUM_HALVES-1:0]        sel_ab,
    input  logic [NUM_HALVES-1:0]        sel_ba,
    input  logic [NUM_HALVES-1:0]        en_ab,
    input  logic [NUM_HALVES-1:0]        en_ba_n,
    input  logic [NUM_HALVES*HALF_W-1:0] a_in,
    output logic [NUM_HALVES*HALF_W-1:0] a_out,
    output logic [NUM_HALVES-1:0]        a_oe,
    input  logic [NUM_HALVES*HALF_W-1:0] b_in,
    output logic [NUM_HALVES*HALF_W-1:0] b_out,
    output logic [NUM_HALVES-1:0]        b_oe
);

    localparam int BUS_W = NUM_HALVES * HALF_W;

    half_ctrl_t       ctrl [NUM_HALVES];
    logic [BUS_W-1:0] a_drv_all;
    logic [BUS_W-1:0] b_drv_all;

    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
        always_comb begin
            ctrl[h] = '{cap_ab : cap_ab[h], cap_ba : cap_ba[h],
                        sel_ab : sel_ab[h], sel_ba : sel_ba[h],
                        en_ab  : en_ab[h],  en_ba_n : en_ba_n[h]};
        end

        xcvr_half #(.WIDTH(HALF_W)) u_half (
            .clk      (clk),
            .rst      (rst),
            .ctrl     (ctrl[h]),
            .a_pad    (a_in[h*HALF_W +: HALF_W]),
            .b_pad    (b_in[h*HALF_W +: HALF_W]),
            .a_drv    (a_drv_all[h*HALF_W +: HALF_W]),
            .a_drv_oe (a_oe[h]),
            .b_drv    (b_drv_all[h*HALF_W +: HALF_W]),
            .b_drv_oe (b_oe[h])
        );
    end

    assign a_out = a_drv_all;
    assign b_out = b_drv_all;

endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker #(
    parameter int HALF_W     = 8,
    parameter int NUM_HALVES = 2
) (
    input logic                         clk,
    input logic                         rst,
    input logic [NUM_HALVES-1:0]        cap_ab,
    input logic [NUM_HALVES-1:0]        cap_ba,
    input logic [NUM_HALVES-1:0]        sel_ab,
    input logic [NUM_HALVES-1:0]        sel_ba,
    input logic [NUM_HALVES-1:0]        en_ab,
    input logic [NUM_HALVES-1:0]        en_ba_n,
    input logic [NUM_HALVES*HALF_W-1:0] a_in,
    input logic [NUM_HALVES*HALF_W-1:0] a_out,
    input logic [NUM_HALVES-1:0]        a_oe,
    input logic [NUM_HALVES*HALF_W-1:0] b_in,
    input logic [NUM_HALVES*HALF_W-1:0] b_out,
    input logic [NUM_HALVES-1:0]        b_oe
);

    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_chk
        p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> (!a_oe[h] && !b_oe[h] &&
                            a_out[h*HALF_W +: HALF_W] == '0 &&
                            b_out[h*HALF_W +: HALF_W] == '0));

        p_capture_a_r2: assert property (@(posedge clk) disable iff (rst)
            ($rose(cap_ab[h]) && sel_ab[h]) |=>
                b_out[h*HALF_W +: HALF_W] == $past(a_in[h*HALF_W +: HALF_W]));

        p_capture_b_r3: assert property (@(posedge clk) disable iff (rst)
            ($rose(cap_ba[h]) && sel_ba[h]) |=>
                a_out[h*HALF_W +: HALF_W] == $past(b_in[h*HALF_W +: HALF_W]));

        p_hold_a_r4: assert property (@(posedge clk) disable iff (rst)
            (sel_ab[h] && $past(sel_ab[h]) && !$rose(cap_ab[h])) |=>
                $stable(b_out[h*HALF_W +: HALF_W]));

        p_hold_b_r4: assert property (@(posedge clk) disable iff (rst)
            (sel_ba[h] && $past(sel_ba[h]) && !$rose(cap_ba[h])) |=>
                $stable(a_out[h*HALF_W +: HALF_W]));

        p_b_enable_r5: assert property (@(posedge clk) disable iff (rst)
            en_ab[h] |=> b_oe[h]);

        p_a_enable_r5: assert property (@(posedge clk) disable iff (rst)
            !en_ba_n[h] |=> a_oe[h]);

        p_isolation_r6: assert property (@(posedge clk) disable iff (rst)
            (!en_ab[h] && en_ba_n[h]) |=> (!a_oe[h] && !b_oe[h]));

        p_live_ab_r7: assert property (@(posedge clk) disable iff (rst)
            !sel_ab[h] |=>
                b_out[h*HALF_W +: HALF_W] == $past(a_in[h*HALF_W +: HALF_W]));

        p_live_ba_r7: assert property (@(posedge clk) disable iff (rst)
            !sel_ba[h] |=>
                a_out[h*HALF_W +: HALF_W] == $past(b_in[h*HALF_W +: HALF_W]));
    end

endmodule

bind bidir_reg_xcvr xcvr_checker #(
    .HALF_W     (HALF_W),
    .NUM_HALVES (NUM_HALVES)
) u_xcvr_checker (
    .clk     (clk),
    .rst     (rst),
    .cap_ab  (cap_ab),
    .cap_ba  (cap_ba),
    .sel_ab  (sel_ab),
    .sel_ba  (sel_ba),
    .en_ab   (en_ab),
    .en_ba_n (en_ba_n),
    .a_in    (a_in),
    .a_out   (a_out),
    .a_oe    (a_oe),
    .b_in    (b_in),
    .b_out   (b_out),
    .b_oe    (b_oe)
);

// File: tb/bidir_reg_xcvr_bench.sv
`timescale 1ns/1ps
module bidir_reg_xcvr_bench;

    localparam int HW = 8;
    localparam int NH = 2;
    localparam int BW = HW * NH;

    typedef struct {
        logic [BW-1:0] a_out;
        logic [NH-1:0] a_oe;
        logic [BW-1:0] b_out;
        logic [NH-1:0] b_oe;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NH-1:0] cap_ab = '0, cap_ba = '0, sel_ab = '0, sel_ba = '0;
    logic [NH-1:0] en_ab = '0, en_ba_n = '1;
    logic [BW-1:0] a_in, b_in, a_out, b_out;
    logic [NH-1:0] a_oe, b_oe;

    // Outside drivers and pad keepers (resolved wire model).
    logic [BW-1:0] ext_a = '0, ext_b = '0;
    logic [NH-1:0] ext_a_en = '0, ext_b_en = '0;
    logic [BW-1:0] keep_a = '0, keep_b = '0;
    logic [BW-1:0] a_bus, b_bus;

    // Reference model state.
    logic [HW-1:0] m_areg [NH];
    logic [HW-1:0] m_breg [NH];
    logic [NH-1:0] m_cab_prev = '0, m_cba_prev = '0;
    logic [BW-1:0] m_aout = '0, m_bout = '0, m_keep_a = '0, m_keep_b = '0;
    logic [NH-1:0] m_aoe = '0, m_boe = '0;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done   = 0;

    always #4 clk = ~clk;

    bidir_reg_xcvr #(.HALF_W(HW), .NUM_HALVES(NH)) u_bidir_reg_xcvr (
        .clk(clk), .rst(rst), .cap_ab(cap_ab), .cap_ba(cap_ba),
        .sel_ab(sel_ab), .sel_ba(sel_ba), .en_ab(en_ab), .en_ba_n(en_ba_n),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
    );

    // Pad resolution: outside driver is strongest, then the block, then the keeper.
    always_comb begin
        for (int h = 0; h < NH; h++) begin
            a_bus[h*HW +: HW] = ext_a_en[h] ? ext_a[h*HW +: HW] :
                                a_oe[h]     ? a_out[h*HW +: HW] : keep_a[h*HW +: HW];
            b_bus[h*HW +: HW] = ext_b_en[h] ? ext_b[h*HW +: HW] :
                                b_oe[h]     ? b_out[h*HW +: HW] : keep_b[h*HW +: HW];
        end
    end
    assign a_in = a_bus;
    assign b_in = b_bus;

    always @(posedge clk) begin
        keep_a <= a_bus;
        keep_b <= b_bus;
    end

    initial begin
        for (int h = 0; h < NH; h++) begin
            m_areg[h] = '0;
            m_breg[h] = '0;
        end
    end

    // Driver: predicts what the next edge produces and queues it.
    task automatic step(input string tag);
        exp_t          e;
        logic [BW-1:0] abus, bbus;
        for (int h = 0; h < NH; h++) begin
            abus[h*HW +: HW] = ext_a_en[h] ? ext_a[h*HW +: HW] :
                               m_aoe[h]    ? m_aout[h*HW +: HW] : m_keep_a[h*HW +: HW];
            bbus[h*HW +: HW] = ext_b_en[h] ? ext_b[h*HW +: HW] :
                               m_boe[h]    ? m_bout[h*HW +: HW] : m_keep_b[h*HW +: HW];
        end
        m_keep_a = abus;
        m_keep_b = bbus;
        for (int h = 0; h < NH; h++) begin
            if (rst) begin
                m_areg[h] = '0;
                m_breg[h] = '0;
                m_aout[h*HW +: HW] = '0;
                m_bout[h*HW +: HW] = '0;
                m_aoe[h] = 1'b0;
                m_boe[h] = 1'b0;
            end else begin
                if (cap_ab[h] && !m_cab_prev[h]) m_areg[h] = abus[h*HW +: HW];
                if (cap_ba[h] && !m_cba_prev[h]) m_breg[h] = bbus[h*HW +: HW];
                m_bout[h*HW +: HW] = sel_ab[h] ? m_areg[h] : abus[h*HW +: HW];
                m_aout[h*HW +: HW] = sel_ba[h] ? m_breg[h] : bbus[h*HW +: HW];
                m_boe[h] = en_ab[h];
                m_aoe[h] = !en_ba_n[h];
            end
        end
        m_cab_prev = cap_ab;
        m_cba_prev = cap_ba;
        e.a_out = m_aout; e.a_oe = m_aoe; e.b_out = m_bout; e.b_oe = m_boe; e.tag = tag;
        q.push_back(e);
        @(posedge clk);
        @(negedge clk);
    endtask

    // Monitor: compares design outputs mid-cycle against the queued prediction.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (a_out !== e.a_out || a_oe !== e.a_oe || b_out !== e.b_out || b_oe !== e.b_oe) begin
                errors++;
                $display("FAIL %s: actual a_out=%h a_oe=%b b_out=%h b_oe=%b expected a_out=%h a_oe=%b b_out=%h b_oe=%b",
                         e.tag, a_out, a_oe, b_out, b_oe, e.a_out, e.a_oe, e.b_out, e.b_oe);
            end
        end
    end

    task automatic isolate();
        cap_ab = '0; cap_ba = '0; sel_ab = '0; sel_ba = '0; en_ab = '0; en_ba_n = '1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        // R1: reset state
        isolate();
        step("R1 in reset");
        step("R1 in reset");
        rst = 1'b0;
        step("R1 first cycle after reset");

        // R6: isolation with outside data on both ports
        ext_a = 16'hA55A; ext_a_en = '1;
        ext_b = 16'h3CC3; ext_b_en = '1;
        step("R6 isolation");
        step("R6 isolation held");

        // R2 R3: capture while isolated
        cap_ab = '1; cap_ba = '1;
        step("R2 R3 capture in isolation");
        cap_ab = '0; cap_ba = '0;
        step("R2 R3 strobe low");

        // R8: stored transfer both ways at once
        ext_a_en = '0; ext_b_en = '0;
        sel_ab = '1; sel_ba = '1; en_ab = '1; en_ba_n = '0;
        step("R8 stored both ways");
        step("R8 stored both ways held");

        // R4: no capture edge, ports change, stored outputs stay
        ext_a = 16'h1234; ext_a_en = '1;
        ext_b = 16'h5678; ext_b_en = '1;
        step("R4 hold under new port data");
        step("R4 hold under new port data");

        // R5 R7: live A to B
        en_ab = '1; en_ba_n = '1; sel_ab = '0; sel_ba = '0; ext_b_en = '0;
        ext_a = 16'h0F0F;
        step("R5 R7 live A to B");
        ext_a = 16'hF00F;
        step("R7 live A to B");
        ext_a = 16'hFFFF;
        step("R7 live A to B");

        // R2 R4 R11: capture in half 0 only, stored select
        sel_ab = '1; cap_ab = 2'b01; ext_a = 16'hBEEF;
        step("R2 R11 capture half 0 only");
        cap_ab = '0; ext_a = 16'h0000;
        step("R4 R11 stored after port change");

        // R5 R7: live B to A
        en_ab = '0; en_ba_n = '0; sel_ab = '0; sel_ba = '0;
        ext_a_en = '0; ext_b_en = '1;
        ext_b = 16'h6996;
        step("R5 R7 live B to A");
        ext_b = 16'h9669;
        step("R7 live B to A");

        // R9: A port carries live B data; capture into both registers
        cap_ab = '1; cap_ba = '1;
        step("R9 capture while A follows B");
        cap_ab = '0; cap_ba = '0;
        ext_b_en = '0;
        en_ab = '1; en_ba_n = '0; sel_ab = '1; sel_ba = '1;
        step("R9 both registers hold B data");
        step("R9 both registers hold B data");

        // R10: bus hold loop
        sel_ab = '0; sel_ba = '0; en_ab = '1; en_ba_n = '0;
        ext_a = 16'hC3A5; ext_a_en = '1;
        step("R10 drive loop");
        step("R10 drive loop");
        step("R10 drive loop");
        ext_a_en = '0;
        for (int i = 0; i < 4; i++) step("R10 bus keeps last value");

        // R11: disturb half 1 while half 0 holds its loop
        ext_a[15:8] = 8'h77; ext_a_en = 2'b10;
        en_ab[1] = 1'b0; sel_ab[1] = 1'b1; cap_ab[1] = 1'b1;
        step("R11 half 1 disturbed");
        cap_ab[1] = 1'b0; en_ba_n[1] = 1'b1;
        step("R11 half 1 disturbed");
        sel_ba[1] = 1'b1;
        step("R11 half 1 disturbed");

        // R1: reset mid-run clears stored values
        ext_a_en = '0; ext_b_en = '0;
        rst = 1'b1;
        step("R1 reset mid-run");
        rst = 1'b0;
        sel_ab = '1; sel_ba = '1; en_ab = '1; en_ba_n = '0; cap_ab = '0; cap_ba = '0;
        step("R1 registers cleared");
        step("R1 registers cleared");

        @(negedge clk);
        #1;
        if (q.size() != 0) begin
            errors++;
            $display("FAIL queue: actual %0d pending expected 0", q.size());
        end
        finish_run();
    end

endmodule